// File: doc/BRIEF.md
# Multi-I/O Serial Flash Read Front End

This block is the device-side command front end of a serial NOR flash. It serves two fast read commands. One is a dual-line read that moves two bits per serial clock. The other is a quad-line read that moves four bits per serial clock. The block runs on a fast system clock and samples chip select, the serial clock and four data-line inputs on every system clock edge. A rising edge of the serial clock captures the host's bits. A falling edge launches read data. Split pad signals (`ioIn`, `ioOut`, `ioOe`) connect the block to bidirectional pads.

A transaction has these phases in order: an 8-clock opcode sent on IO0, a 24-bit start address, an 8-bit mode byte and, for the quad read only, four dummy clocks. After that the block streams bytes from an asynchronous byte-wide memory read port, and the address steps up by one after each byte. If the mode byte carries the continuation pattern, the next chip-select cycle omits the opcode and starts directly with the address, using the same line width as before. Any incomplete or non-matching continuation attempt returns the block to opcode-first operation. This is how an all-ones reset burst clears the continuous-read state.

Top module: `flashMioRead`

## Requirements
- R1: After reset `ioOe` and `ioOut` are all zero, and the first transaction is expected to start with an opcode.
- R2: Opcode BBh (sent MSB first on IO0) starts a dual read. The address is taken in 12 clocks and the mode byte in 4 clocks, two bits per clock with IO1 as the more significant bit. Data follows with no dummy clocks: each clock drives a bit pair on IO1/IO0, most significant pair first, with `ioOe` = 0011b.
- R3: Opcode EBh starts a quad read. The address is taken in 6 clocks and the mode byte in 2 clocks on IO3..IO0, followed by 4 dummy clocks. Each data byte is sent as two nibbles, upper nibble first, with `ioOe` = 1111b.
- R4: While `quadEn` is low, EBh is ignored, and the data lines stay undriven until chip select rises.
- R5: Any opcode other than BBh or EBh, FFh included, leaves the data lines undriven for the whole chip-select cycle.
- R6: A mode byte whose bits 5:4 equal 10b makes the next chip-select cycle start at the address phase with no opcode, in the same dual or quad width. Mode bits 7:6 and 3:0 have no effect on this.
- R7: A mode byte with any other value in bits 5:4 makes the next cycle expect the full opcode again.
- R8: The read address starts at any byte location, advances by one per byte and wraps from FFFFFFh to 000000h. It is presented on `memAddr`, and the matching `memRdata` is sent.
- R9: The data lines are undriven during the opcode, address, mode and dummy phases. Output enable first turns on at the falling serial-clock edge that starts the first data clock, and it turns on only while the serial clock is low.
- R10: A high chip select releases every output one system clock later and ends the transaction. If chip select rises before a continuation transaction's mode byte is complete, the continuous-read state is cleared. A mode byte of FFh also clears it, so FFh in quad width or FFFFh in dual width returns the block to opcode-first operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| quadEn | input | 1 | Quad-enable status bit; gates the quad read |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host, idle low |
| ioIn | input | 4 | Data-line input values, IO3..IO0 |
| ioOut | output | 4 | Data-line output values, IO3..IO0 |
| ioOe | output | 4 | Per-line output enable, high to drive |
| memAddr | output | 24 | Byte address to the memory array |
| memRdata | input | 8 | Byte read from `memAddr`, combinational |

## Verification
The block registers every serial-clock edge it detects one system clock after the edge. A captured bit therefore takes effect one system clock after the rising edge, and a data slot appears on `ioOut` one system clock after the falling edge. The bench holds each serial-clock half for four system clocks. It samples the read data just before it raises the clock, three system clocks after the data is due. It checks the enables at the end of the last command clock, before the first falling edge. The release after chip select is checked half a serial period later, well past its one-clock latency.

// File: rtl/flashMioReadPkg.sv
package flashMioReadPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_MODE,
    PH_DUMMY,
    PH_DATA,
    PH_SKIP
  } phase_t;

  typedef struct packed {
    logic       shiftOpc;
    logic       shiftAddr;
    logic       shiftMode;
    logic       driveSlot;
    logic       incAddr;
    logic       quad;
    logic [1:0] slotIdx;
  } strobe_t;

endpackage

// File: rtl/flashRdCtrl.sv
module flashRdCtrl
  import flashMioReadPkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter logic [7:0] OPC_DUAL = 8'hBB,
  parameter logic [7:0] OPC_QUAD = 8'hEB,
  parameter int QUAD_DUMMY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       quadEn,
  input  logic       csN,
  input  logic       sclkRise,
  input  logic       sclkFall,
  input  logic [7:0] opcNext,
  input  logic [1:0] modeCtlBits,
  output strobe_t    strb,
  output logic       outEn
);

  localparam int OPC_CLKS       = 8;
  localparam int DUAL_ADDR_CLKS = ADDR_W / 2;
  localparam int QUAD_ADDR_CLKS = ADDR_W / 4;
  localparam int DUAL_MODE_CLKS = 4;
  localparam int QUAD_MODE_CLKS = 2;
  localparam int MAX_A          = (DUAL_ADDR_CLKS > OPC_CLKS) ? DUAL_ADDR_CLKS : OPC_CLKS;
  localparam int MAX_CLKS       = (MAX_A > QUAD_DUMMY) ? MAX_A : QUAD_DUMMY;
  localparam int CNT_W          = $clog2(MAX_CLKS + 1);
  localparam logic [1:0] CONT_PATTERN = 2'b10;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic             atLast;
  logic             isQuad;
  logic             contFlag;
  logic [1:0]       slotCnt;
  logic [1:0]       lastSlot;
  logic             oeReg;

  always_comb begin
    unique case (phase)
      PH_OPC:   lastCnt = CNT_W'(OPC_CLKS - 1);
      PH_ADDR:  lastCnt = isQuad ? CNT_W'(QUAD_ADDR_CLKS - 1) : CNT_W'(DUAL_ADDR_CLKS - 1);
      PH_MODE:  lastCnt = isQuad ? CNT_W'(QUAD_MODE_CLKS - 1) : CNT_W'(DUAL_MODE_CLKS - 1);
      PH_DUMMY: lastCnt = CNT_W'(QUAD_DUMMY - 1);
      default:  lastCnt = '0;
    endcase
  end

  assign atLast   = (cnt == lastCnt);
  assign lastSlot = isQuad ? 2'd1 : 2'd3;

  always_comb begin
    strb.shiftOpc  = !csN && sclkRise && (phase == PH_OPC);
    strb.shiftAddr = !csN && sclkRise && (phase == PH_ADDR);
    strb.shiftMode = !csN && sclkRise && (phase == PH_MODE);
    strb.driveSlot = !csN && sclkFall && (phase == PH_DATA);
    strb.incAddr   = strb.driveSlot && (slotCnt == lastSlot);
    strb.quad      = isQuad;
    strb.slotIdx   = slotCnt;
  end

  assign outEn = oeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      isQuad   <= 1'b0;
      contFlag <= 1'b0;
      slotCnt  <= '0;
      oeReg    <= 1'b0;
    end else if (csN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      slotCnt <= '0;
      oeReg   <= 1'b0;
      if (phase == PH_ADDR || phase == PH_MODE) begin
        contFlag <= 1'b0;
      end
    end else if (phase == PH_IDLE) begin
      phase <= contFlag ? PH_ADDR : PH_OPC;
      cnt   <= '0;
    end else if (sclkRise) begin
      unique case (phase)
        PH_OPC: begin
          if (atLast) begin
            cnt <= '0;
            if (opcNext == OPC_DUAL) begin
              isQuad <= 1'b0;
              phase  <= PH_ADDR;
            end else if (opcNext == OPC_QUAD && quadEn) begin
              isQuad <= 1'b1;
              phase  <= PH_ADDR;
            end else begin
              phase <= PH_SKIP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          if (atLast) begin
            cnt   <= '0;
            phase <= PH_MODE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_MODE: begin
          if (atLast) begin
            cnt      <= '0;
            contFlag <= (modeCtlBits == CONT_PATTERN);
            phase    <= (isQuad && QUAD_DUMMY > 0) ? PH_DUMMY : PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (atLast) begin
            cnt   <= '0;
            phase <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (sclkFall && phase == PH_DATA) begin
      oeReg   <= 1'b1;
      slotCnt <= (slotCnt == lastSlot) ? 2'd0 : slotCnt + 2'd1;
    end
  end

endmodule

// File: rtl/flashRdPath.sv
module flashRdPath
  import flashMioReadPkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic [3:0]        ioIn,
  input  strobe_t           strb,
  input  logic              outEn,
  input  logic [7:0]        memRdata,
  output logic              sclkRise,
  output logic              sclkFall,
  output logic [7:0]        opcNext,
  output logic [1:0]        modeCtlBits,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe
);

  localparam int DUAL_W = 2;
  localparam int QUAD_W = 4;

  logic              sclkQ;
  logic [7:0]        opcReg;
  logic [7:0]        modeReg;
  logic [7:0]        modeNext;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] addrNext;
  logic [7:0]        shifted;
  logic [3:0]        slotBits;
  logic [3:0]        outReg;

  assign sclkRise = sclk && !sclkQ;
  assign sclkFall = !sclk && sclkQ;

  assign opcNext     = {opcReg[6:0], ioIn[0]};
  assign modeNext    = strb.quad ? {modeReg[7-QUAD_W:0], ioIn[QUAD_W-1:0]}
                                 : {modeReg[7-DUAL_W:0], ioIn[DUAL_W-1:0]};
  assign modeCtlBits = modeNext[5:4];
  assign addrNext    = strb.quad ? {addrReg[ADDR_W-1-QUAD_W:0], ioIn[QUAD_W-1:0]}
                                 : {addrReg[ADDR_W-1-DUAL_W:0], ioIn[DUAL_W-1:0]};

  always_comb begin
    shifted  = strb.quad ? (memRdata << {strb.slotIdx, 2'b00})
                         : (memRdata << {strb.slotIdx, 1'b0});
    slotBits = strb.quad ? shifted[7:4] : {2'b00, shifted[7:6]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      opcReg  <= '0;
      modeReg <= '0;
      addrReg <= '0;
      outReg  <= '0;
    end else begin
      sclkQ <= sclk;
      if (strb.shiftOpc)  opcReg  <= opcNext;
      if (strb.shiftMode) modeReg <= modeNext;
      if (strb.shiftAddr) begin
        addrReg <= addrNext;
      end else if (strb.incAddr) begin
        addrReg <= addrReg + 1'b1;
      end
      if (strb.driveSlot) outReg <= slotBits;
    end
  end

  assign memAddr = addrReg;
  assign ioOe    = outEn ? (strb.quad ? 4'hF : 4'h3) : 4'h0;
  assign ioOut   = outReg & ioOe;

endmodule

// File: rtl/flashMioRead.sv
module flashMioRead
  import flashMioReadPkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter logic [7:0] OPC_DUAL = 8'hBB,
  parameter logic [7:0] OPC_QUAD = 8'hEB,
  parameter int QUAD_DUMMY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              quadEn,
  input  logic              csN,
  input  logic              sclk,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdata
);

  strobe_t    strb;
  logic       outEn;
  logic       sclkRise;
  logic       sclkFall;
  logic [7:0] opcNext;
  logic [1:0] modeCtlBits;

  flashRdCtrl #(
    .ADDR_W(ADDR_W), .OPC_DUAL(OPC_DUAL), .OPC_QUAD(OPC_QUAD), .QUAD_DUMMY(QUAD_DUMMY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .quadEn(quadEn), .csN(csN),
    .sclkRise(sclkRise), .sclkFall(sclkFall),
    .opcNext(opcNext), .modeCtlBits(modeCtlBits),
    .strb(strb), .outEn(outEn)
  );

  flashRdPath #(.ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rstN(rstN), .sclk(sclk), .ioIn(ioIn),
    .strb(strb), .outEn(outEn), .memRdata(memRdata),
    .sclkRise(sclkRise), .sclkFall(sclkFall),
    .opcNext(opcNext), .modeCtlBits(modeCtlBits),
    .memAddr(memAddr), .ioOut(ioOut), .ioOe(ioOe)
  );

endmodule

// File: rtl/flashMioReadChk.sv
module flashMioReadChk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              sclk,
  input logic [3:0]        ioOut,
  input logic [3:0]        ioOe,
  input logic [ADDR_W-1:0] memAddr
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  AST_RELEASE_ON_CS: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (ioOe == 4'h0)); // R10

  AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == 4'h0) || (ioOe == 4'h3) || (ioOe == 4'hF)); // R3

  AST_OE_ON_LOW_CLK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioOe != 4'h0) |-> !sclk); // R9

  AST_OUT_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk) && ioOe != 4'h0 && $past(ioOe) != 4'h0) |-> $stable(ioOut)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$past(csN) && ioOe != 4'h0 && $past(ioOe) != 4'h0)
      |-> (memAddr == $past(memAddr) || memAddr == $past(memAddr) + ONE)); // R8

endmodule

bind flashMioRead flashMioReadChk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
  .ioOut(ioOut), .ioOe(ioOe), .memAddr(memAddr)
);

// File: tb/tb_flashMioRead.sv
`timescale 1ns/1ps
module tb_flashMioRead;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        quadEn = 1'b1;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic [3:0]  ioIn = 4'h0;
  logic [3:0]  ioOut;
  logic [3:0]  ioOe;
  logic [23:0] memAddr;
  logic [7:0]  memRdata;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  bit contOn = 1'b0;
  bit contQuad = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] memFn(input logic [23:0] a);
    logic [7:0] v;
    v = a[7:0] + 8'(a[15:8] * 3) + 8'(a[23:16] * 5);
    return v ^ 8'hA5;
  endfunction

  assign memRdata = memFn(memAddr);

  flashMioRead dut (
    .clk(clk), .rstN(rstN), .quadEn(quadEn), .csN(csN), .sclk(sclk),
    .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe), .memAddr(memAddr), .memRdata(memRdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (4) @(negedge clk);
  endtask

  task automatic clkIn(input logic [3:0] d);
    ioIn = d;
    sclk = 1'b0;
    halfWait();
    sclk = 1'b1;
    halfWait();
  endtask

  task automatic clkOut(output logic [3:0] q, output logic [3:0] oe);
    sclk = 1'b0;
    halfWait();
    q  = ioOut;
    oe = ioOe;
    sclk = 1'b1;
    halfWait();
  endtask

  task automatic endCs(input string tag);
    sclk = 1'b0;
    halfWait();
    csN = 1'b1;
    halfWait();
    check(ioOe == 4'h0, {tag, " R10 release"}, 32'(ioOe), 32'h0);
  endtask

  task automatic xfer(input bit sendOpc, input logic [7:0] opc, input bit quad,
                      input logic [23:0] addr, input logic [7:0] mode,
                      input int nBytes, input bit expData, input string tag);
    logic [3:0] q;
    logic [3:0] oe;
    logic [7:0] got;
    logic [3:0] oeExp;
    bit oeOk;
    csN = 1'b0;
    halfWait();
    if (sendOpc) for (int i = 7; i >= 0; i--) clkIn({3'b000, opc[i]});
    if (quad) begin
      for (int k = 0; k < 6; k++) clkIn(addr[23-4*k -: 4]);
      for (int k = 0; k < 2; k++) clkIn(mode[7-4*k -: 4]);
      for (int k = 0; k < 4; k++) clkIn(4'h0);
    end else begin
      for (int k = 0; k < 12; k++) clkIn({2'b00, addr[23-2*k -: 2]});
      for (int k = 0; k < 4; k++) clkIn({2'b00, mode[7-2*k -: 2]});
    end
    check(ioOe == 4'h0, {tag, " R9 undriven before data"}, 32'(ioOe), 32'h0);
    oeExp = expData ? (quad ? 4'hF : 4'h3) : 4'h0;
    for (int b = 0; b < nBytes; b++) begin
      logic [23:0] a2;
      a2 = addr + 24'(b);
      got = 8'h00;
      oeOk = 1'b1;
      for (int s = 0; s < (quad ? 2 : 4); s++) begin
        clkOut(q, oe);
        got = quad ? {got[3:0], q} : {got[5:0], q[1:0]};
        if (oe != oeExp) oeOk = 1'b0;
      end
      check(oeOk, {tag, " R9 enable pattern"}, 32'(oe), 32'(oeExp));
      if (expData)
        check(got == memFn(a2), {tag, " R8 data byte"}, {8'h0, a2}, 32'(memFn(a2)));
    end
    endCs(tag);
  endtask

  task automatic partial(input int nClks, input logic [3:0] d, input string tag);
    csN = 1'b0;
    halfWait();
    for (int i = 0; i < nClks; i++) clkIn(d);
    endCs(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ioOe == 4'h0, "R1 reset oe", 32'(ioOe), 32'h0);
    check(ioOut == 4'h0, "R1 reset out", 32'(ioOut), 32'h0);

    // R2 dual read, mode 00h so next needs opcode (R7)
    xfer(1, 8'hBB, 0, 24'h123456, 8'h00, 3, 1, "R2 dual");
    // R3 quad read with mode AFh: bits 5:4 = 10 -> continuation (R6)
    xfer(1, 8'hEB, 1, 24'hABCDEF, 8'hAF, 2, 1, "R3 quad");
    xfer(0, 8'h00, 1, 24'h000100, 8'h00, 2, 1, "R6 quad no opcode");
    xfer(1, 8'hEB, 1, 24'h004321, 8'h00, 1, 1, "R7 quad opcode again");
    // R6 dual continuation, then mode 30h clears it (R7)
    xfer(1, 8'hBB, 0, 24'h00F00D, 8'h25, 1, 1, "R6 dual set");
    xfer(0, 8'h00, 0, 24'h777777, 8'h30, 2, 1, "R6 dual no opcode");
    xfer(1, 8'hBB, 0, 24'h0A0B0C, 8'hD0, 1, 1, "R7 dual opcode again");
    // R4 quad disabled
    quadEn = 1'b0;
    xfer(1, 8'hEB, 1, 24'h000010, 8'h20, 2, 0, "R4 quad disabled");
    quadEn = 1'b1;
    xfer(1, 8'hBB, 0, 24'h000020, 8'h00, 1, 1, "R4 no continuation left");
    // R5 foreign opcodes
    xfer(1, 8'h03, 0, 24'h000030, 8'h20, 2, 0, "R5 other opcode");
    xfer(1, 8'hFF, 1, 24'hFFFFFF, 8'hFF, 1, 0, "R5 opcode FFh");
    // R8 wrap
    xfer(1, 8'hEB, 1, 24'hFFFFFE, 8'h00, 4, 1, "R8 quad wrap");
    xfer(1, 8'hBB, 0, 24'hFFFFFF, 8'h00, 2, 1, "R8 dual wrap");
    // R10 quad reset burst FFh (8 clocks of ones)
    xfer(1, 8'hEB, 1, 24'h111111, 8'h20, 1, 1, "R10 quad set");
    partial(8, 4'hF, "R10 FFh burst");
    xfer(1, 8'hBB, 0, 24'h222222, 8'h00, 1, 1, "R10 after FFh");
    // R10 dual reset burst FFFFh (16 clocks of ones)
    xfer(1, 8'hBB, 0, 24'h333333, 8'h20, 1, 1, "R10 dual set");
    partial(16, 4'hF, "R10 FFFFh burst");
    xfer(1, 8'hEB, 1, 24'h444444, 8'h00, 1, 1, "R10 after FFFFh");
    // R10 abort mid-address clears continuation; abort mid-data keeps it
    xfer(1, 8'hEB, 1, 24'h555555, 8'h20, 1, 1, "R10 set again");
    partial(3, 4'h0, "R10 short abort");
    xfer(1, 8'hEB, 1, 24'h666666, 8'h20, 1, 1, "R10 opcode after abort");
    xfer(0, 8'h00, 1, 24'h676767, 8'h20, 1, 1, "R6 kept after data abort");

    // random mix tracked by a bench model of the continuation state
    contOn = 1'b1;
    contQuad = 1'b1;
    for (int it = 0; it < 24; it++) begin
      logic [23:0] a;
      logic [7:0] m;
      bit qd;
      int nb;
      a  = 24'($urandom);
      m  = 8'($urandom);
      if ((it % 3) == 0) m[5:4] = 2'b10;
      qd = contOn ? contQuad : bit'($urandom % 2);
      nb = 1 + int'($urandom % 4);
      xfer(!contOn, qd ? 8'hEB : 8'hBB, qd, a, m, nb, 1, contOn ? "R6 random cont" : "R2 R3 random");
      contOn   = (m[5:4] == 2'b10);
      contQuad = qd;
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule